// File: doc/BRIEF.md
# Reader Field Strength Indicator

This block watches two sampled field-strength channels, one low-frequency and one high-frequency, and shows on four indicator LEDs whether an external reader field is there and how strong the high-frequency field is. The first accepted reading of each channel after reset becomes that channel's reference level. After that, the block follows each channel with a tracked level that moves only on large jumps. Each such jump gives a change event that reports the old level, the new level and how many readings came in since the last event.

The block has a detect mode and a strength mode. In detect mode one LED marks low-frequency presence and another marks high-frequency presence. In strength mode the high-frequency tracked level is placed into one of seven bands, each one seventh of the largest level seen so far, and each band has its own fixed LED pattern. A cleaned button pulse moves the block from detect to strength and then to a stopped state with all LEDs dark. A two-bit limit input can switch off either channel. The band width (the maximum divided by seven) is worked out by a small sequential divider each time the maximum changes. The band comparison therefore only needs multiplies by small constants.

Top module: `fieldMeter`

## Requirements
- R1: After reset all LEDs are off and no event strobe is high. The first accepted reading of a channel sets both its reference and its tracked level and raises no event. For the high-frequency channel that reading also sets the running maximum.
- R2: A channel has a field when its tracked level and its reference differ by more than THRESH counts. In detect mode `ledOut` is {A,B,C,D} = {0, high-frequency field, 0, low-frequency field}.
- R3: An accepted reading that differs from the tracked level by more than THRESH replaces the tracked level. One cycle after the reading, that channel's event strobe goes high for one cycle and carries the old and new levels. A reading within THRESH leaves the level unchanged and raises no event.
- R4: The event count is the number of accepted readings since the previous event (or since the reference reading), counting the reading that caused the event. It saturates at its all-ones value and restarts from zero after each event.
- R5: The high-frequency maximum is raised whenever a level update brings a new level above it. The band width, the maximum divided by 7 rounded down, follows within ADC_W+2 cycles.
- R6: In strength mode, with step = max/7, a field present and a level above 0, the band is the number of k in 1..6 for which level > k*step. Bands 6 down to 0 show {A,B,C,D} = 1111, 1101, 0101, 0001, 0100, 1000, 0010.
- R7: In strength mode all LEDs are off when the high-frequency channel has no field or its tracked level is 0. The low-frequency channel does not affect the LEDs in this mode.
- R8: An accepted button press goes from detect to strength, and the next one goes to stopped. In the stopped state LEDs are off, readings are ignored, no events are raised and further presses have no effect.
- R9: For HOLDOFF_CYCLES cycles after an accepted press, further presses are ignored.
- R10: With limit = 1 the high-frequency channel is off, and with limit = 2 the low-frequency channel is off. An off channel ignores its readings, raises no events and shows no field. Limit values 0 and 3 leave both channels on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| limit | input | 2 | Channel disable: 1 turns off high-frequency, 2 turns off low-frequency |
| buttonPress | input | 1 | One-cycle pulse for a cleaned button press |
| lfValid | input | 1 | Low-frequency reading strobe |
| lfSample | input | ADC_W | Low-frequency reading |
| hfValid | input | 1 | High-frequency reading strobe |
| hfSample | input | ADC_W | High-frequency reading |
| ledOut | output | 4 | LED levels, bit 3 = A, bit 2 = B, bit 1 = C, bit 0 = D |
| lfEvent | output | 1 | Low-frequency change event strobe |
| lfEvOld | output | ADC_W | Low-frequency level before the change |
| lfEvNew | output | ADC_W | Low-frequency level after the change |
| lfEvCount | output | CNT_W | Low-frequency readings since the previous event |
| hfEvent | output | 1 | High-frequency change event strobe |
| hfEvOld | output | ADC_W | High-frequency level before the change |
| hfEvNew | output | ADC_W | High-frequency level after the change |
| hfEvCount | output | CNT_W | High-frequency readings since the previous event |

## Verification
The assertions check on every cycle that the stopped state stays dark and quiet, that detect mode never lights A or C, and that every event jumps by more than the threshold. They also check that a disabled channel raises no events, that the maximum never falls below a reported level and that an idle divider holds exactly max/7. The band patterns, the hysteresis of the tracked level, the saturating count, the hold-off window and the mode order can only be shown by the bench's sweeps. The bench runs the high-frequency level up and down across the whole input range while the maximum grows, and compares each LED result against band arithmetic.

// File: rtl/fmPkg.sv
package fmPkg;

  typedef enum logic [1:0] {
    MODE_DETECT   = 2'd0,
    MODE_STRENGTH = 2'd1,
    MODE_STOPPED  = 2'd2
  } modeT;

  typedef struct packed {
    logic lfFirst;
    logic lfTake;
    logic hfFirst;
    logic hfTake;
    logic lfEn;
    logic hfEn;
  } ctrlStrobeT;

  localparam int BANDS = 7;
  localparam logic [1:0] LIMIT_NO_HF = 2'd1;
  localparam logic [1:0] LIMIT_NO_LF = 2'd2;

  // LED bits {A,B,C,D} for each strength band, top band is 6
  function automatic logic [3:0] bandLeds(input logic [2:0] band);
    logic [3:0] pat;
    case (band)
      3'd6:    pat = 4'b1111;
      3'd5:    pat = 4'b1101;
      3'd4:    pat = 4'b0101;
      3'd3:    pat = 4'b0001;
      3'd2:    pat = 4'b0100;
      3'd1:    pat = 4'b1000;
      3'd0:    pat = 4'b0010;
      default: pat = 4'b0000;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/fmCtrl.sv
module fmCtrl
  import fmPkg::*;
#(
  parameter int HOLDOFF_CYCLES = 50_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       buttonPress,
  input  logic [1:0] limit,
  input  logic       lfValid,
  input  logic       hfValid,
  output modeT       mode,
  output ctrlStrobeT strobes
);
  localparam int HOLD_W = $clog2(HOLDOFF_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLDOFF_CYCLES);

  modeT modeQ;
  logic [HOLD_W-1:0] holdCnt;
  logic lfHave, hfHave;
  logic running, lfEn, hfEn, lfAcc, hfAcc, pressOk;

  always_comb begin
    running = (modeQ != MODE_STOPPED);
    lfEn    = (limit != LIMIT_NO_LF);
    hfEn    = (limit != LIMIT_NO_HF);
    lfAcc   = lfValid && lfEn && running;
    hfAcc   = hfValid && hfEn && running;
    pressOk = buttonPress && (holdCnt == '0) && running;
    strobes.lfFirst = lfAcc && !lfHave;
    strobes.lfTake  = lfAcc && lfHave;
    strobes.hfFirst = hfAcc && !hfHave;
    strobes.hfTake  = hfAcc && hfHave;
    strobes.lfEn    = lfEn;
    strobes.hfEn    = hfEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_DETECT;
      holdCnt <= '0;
      lfHave  <= 1'b0;
      hfHave  <= 1'b0;
    end else begin
      if (pressOk) begin
        modeQ   <= (modeQ == MODE_DETECT) ? MODE_STRENGTH : MODE_STOPPED;
        holdCnt <= HOLD_LOAD;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
      if (strobes.lfFirst) lfHave <= 1'b1;
      if (strobes.hfFirst) hfHave <= 1'b1;
    end
  end

  assign mode = modeQ;

endmodule

// File: rtl/fmChannel.sv
module fmChannel #(
  parameter int ADC_W  = 10,
  parameter int THRESH = 10,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             first,
  input  logic             take,
  input  logic [ADC_W-1:0] sample,
  output logic [ADC_W-1:0] level,
  output logic             present,
  output logic             bigStep,
  output logic             evStrobe,
  output logic [ADC_W-1:0] evOld,
  output logic [ADC_W-1:0] evNew,
  output logic [CNT_W-1:0] evCount
);
  localparam logic [ADC_W-1:0] THR     = ADC_W'(THRESH);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [ADC_W-1:0] levelQ, baseQ;
  logic [CNT_W-1:0] cntQ, cntInc;

  function automatic logic [ADC_W-1:0] absDiff(input logic [ADC_W-1:0] a,
                                                input logic [ADC_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  always_comb begin
    bigStep = take && (absDiff(sample, levelQ) > THR);
    present = absDiff(levelQ, baseQ) > THR;
    cntInc  = (cntQ == CNT_TOP) ? cntQ : cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ   <= '0;
      baseQ    <= '0;
      cntQ     <= '0;
      evStrobe <= 1'b0;
      evOld    <= '0;
      evNew    <= '0;
      evCount  <= '0;
    end else begin
      evStrobe <= 1'b0;
      if (first) begin
        baseQ  <= sample;
        levelQ <= sample;
        cntQ   <= '0;
      end else if (bigStep) begin
        evStrobe <= 1'b1;
        evOld    <= levelQ;
        evNew    <= sample;
        evCount  <= cntInc;
        levelQ   <= sample;
        cntQ     <= '0;
      end else if (take) begin
        cntQ <= cntInc;
      end
    end
  end

  assign level = levelQ;

endmodule

// File: rtl/fmStepDiv.sv
module fmStepDiv #(
  parameter int W       = 10,
  parameter int DIVISOR = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  output logic [W-1:0] quotient,
  output logic         busy
);
  localparam int RW = $clog2(DIVISOR) + 1;
  localparam int IW = $clog2(W + 1);
  localparam logic [RW-1:0] DV     = RW'(DIVISOR);
  localparam logic [IW-1:0] STEPS  = IW'(W);
  localparam logic [IW-1:0] LASTIX = IW'(1);

  logic [W-1:0]  shQ, quoQ, resQ;
  logic [RW-1:0] remQ, remShift, remNext;
  logic [IW-1:0] idxQ;
  logic          busyQ, geq;

  always_comb begin
    remShift = {remQ[RW-2:0], shQ[W-1]};
    geq      = (remShift >= DV);
    remNext  = geq ? (remShift - DV) : remShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shQ   <= '0;
      quoQ  <= '0;
      resQ  <= '0;
      remQ  <= '0;
      idxQ  <= '0;
      busyQ <= 1'b0;
    end else if (start) begin
      shQ   <= dividend;
      quoQ  <= '0;
      remQ  <= '0;
      idxQ  <= STEPS;
      busyQ <= 1'b1;
    end else if (busyQ) begin
      shQ  <= shQ << 1;
      remQ <= remNext;
      quoQ <= {quoQ[W-2:0], geq};
      idxQ <= idxQ - 1'b1;
      if (idxQ == LASTIX) begin
        busyQ <= 1'b0;
        resQ  <= {quoQ[W-2:0], geq};
      end
    end
  end

  assign quotient = resQ;
  assign busy     = busyQ;

endmodule

// File: rtl/fmDatapath.sv
module fmDatapath
  import fmPkg::*;
#(
  parameter int ADC_W  = 10,
  parameter int THRESH = 10,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  modeT             mode,
  input  ctrlStrobeT       strobes,
  input  logic [ADC_W-1:0] lfSample,
  input  logic [ADC_W-1:0] hfSample,
  output logic [3:0]       ledOut,
  output logic             lfEvent,
  output logic [ADC_W-1:0] lfEvOld,
  output logic [ADC_W-1:0] lfEvNew,
  output logic [CNT_W-1:0] lfEvCount,
  output logic             hfEvent,
  output logic [ADC_W-1:0] hfEvOld,
  output logic [ADC_W-1:0] hfEvNew,
  output logic [CNT_W-1:0] hfEvCount,
  output logic [ADC_W-1:0] hfMax,
  output logic [ADC_W-1:0] hfStep,
  output logic             divBusy
);
  localparam int NCH = 2;   // index 0 low-frequency, 1 high-frequency
  localparam int EW  = ADC_W + 3;

  logic             firstV  [NCH];
  logic             takeV   [NCH];
  logic [ADC_W-1:0] sampleV [NCH];
  logic [ADC_W-1:0] levelV  [NCH];
  logic             presV   [NCH];
  logic             bigV    [NCH];
  logic             evV     [NCH];
  logic [ADC_W-1:0] oldV    [NCH];
  logic [ADC_W-1:0] newV    [NCH];
  logic [CNT_W-1:0] cntV    [NCH];

  assign firstV[0]  = strobes.lfFirst;
  assign takeV[0]   = strobes.lfTake;
  assign sampleV[0] = lfSample;
  assign firstV[1]  = strobes.hfFirst;
  assign takeV[1]   = strobes.hfTake;
  assign sampleV[1] = hfSample;

  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    fmChannel #(.ADC_W(ADC_W), .THRESH(THRESH), .CNT_W(CNT_W)) chan (
      .clk(clk), .rstN(rstN),
      .first(firstV[ch]), .take(takeV[ch]), .sample(sampleV[ch]),
      .level(levelV[ch]), .present(presV[ch]), .bigStep(bigV[ch]),
      .evStrobe(evV[ch]), .evOld(oldV[ch]), .evNew(newV[ch]), .evCount(cntV[ch])
    );
  end

  assign lfEvent   = evV[0];
  assign lfEvOld   = oldV[0];
  assign lfEvNew   = newV[0];
  assign lfEvCount = cntV[0];
  assign hfEvent   = evV[1];
  assign hfEvOld   = oldV[1];
  assign hfEvNew   = newV[1];
  assign hfEvCount = cntV[1];

  // running maximum of the high-frequency level
  logic [ADC_W-1:0] maxQ;
  logic             maxLoad;

  assign maxLoad = strobes.hfFirst || (bigV[1] && (hfSample > maxQ));

  always_ff @(posedge clk) begin
    if (!rstN)        maxQ <= '0;
    else if (maxLoad) maxQ <= hfSample;
  end

  fmStepDiv #(.W(ADC_W), .DIVISOR(BANDS)) stepDiv (
    .clk(clk), .rstN(rstN), .start(maxLoad), .dividend(hfSample),
    .quotient(hfStep), .busy(divBusy)
  );

  assign hfMax = maxQ;

  // band index: count of thresholds k*step (k = 1..BANDS-1) below the level
  logic [EW-1:0]    levelExt, stepExt;
  logic [BANDS-2:0] above;
  logic [2:0]       band;

  assign levelExt = EW'(levelV[1]);
  assign stepExt  = EW'(hfStep);

  for (genvar k = 1; k < BANDS; k++) begin : gThr
    assign above[k-1] = levelExt > (EW'(k) * stepExt);
  end

  always_comb begin
    band = '0;
    for (int i = 0; i < BANDS - 1; i++) band = band + 3'(above[i]);
  end

  logic lfField, hfField;
  logic [3:0] ledNext;

  always_comb begin
    lfField = presV[0] && strobes.lfEn;
    hfField = presV[1] && strobes.hfEn;
    case (mode)
      MODE_DETECT:   ledNext = {1'b0, hfField, 1'b0, lfField};
      MODE_STRENGTH: ledNext = (hfField && (levelV[1] != '0)) ? bandLeds(band) : 4'b0000;
      default:       ledNext = 4'b0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) ledOut <= 4'b0000;
    else       ledOut <= ledNext;
  end

endmodule

// File: rtl/fieldMeter.sv
module fieldMeter
  import fmPkg::*;
#(
  parameter int ADC_W          = 10,
  parameter int THRESH         = 10,
  parameter int CNT_W          = 16,
  parameter int HOLDOFF_CYCLES = 50_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       limit,
  input  logic             buttonPress,
  input  logic             lfValid,
  input  logic [ADC_W-1:0] lfSample,
  input  logic             hfValid,
  input  logic [ADC_W-1:0] hfSample,
  output logic [3:0]       ledOut,
  output logic             lfEvent,
  output logic [ADC_W-1:0] lfEvOld,
  output logic [ADC_W-1:0] lfEvNew,
  output logic [CNT_W-1:0] lfEvCount,
  output logic             hfEvent,
  output logic [ADC_W-1:0] hfEvOld,
  output logic [ADC_W-1:0] hfEvNew,
  output logic [CNT_W-1:0] hfEvCount
);
  modeT             modeW;
  ctrlStrobeT       strobeW;
  logic [ADC_W-1:0] hfMaxW, hfStepW;
  logic             divBusyW;

  fmCtrl #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .buttonPress(buttonPress), .limit(limit),
    .lfValid(lfValid), .hfValid(hfValid), .mode(modeW), .strobes(strobeW)
  );

  fmDatapath #(.ADC_W(ADC_W), .THRESH(THRESH), .CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .mode(modeW), .strobes(strobeW),
    .lfSample(lfSample), .hfSample(hfSample), .ledOut(ledOut),
    .lfEvent(lfEvent), .lfEvOld(lfEvOld), .lfEvNew(lfEvNew), .lfEvCount(lfEvCount),
    .hfEvent(hfEvent), .hfEvOld(hfEvOld), .hfEvNew(hfEvNew), .hfEvCount(hfEvCount),
    .hfMax(hfMaxW), .hfStep(hfStepW), .divBusy(divBusyW)
  );

endmodule

// File: rtl/fmCheck.sv
module fmCheck
  import fmPkg::*;
#(
  parameter int ADC_W  = 10,
  parameter int THRESH = 10
) (
  input logic             clk,
  input logic             rstN,
  input modeT             mode,
  input logic [1:0]       limit,
  input logic [3:0]       ledOut,
  input logic             lfEvent,
  input logic [ADC_W-1:0] lfEvOld,
  input logic [ADC_W-1:0] lfEvNew,
  input logic             hfEvent,
  input logic [ADC_W-1:0] hfEvOld,
  input logic [ADC_W-1:0] hfEvNew,
  input logic [ADC_W-1:0] hfMax,
  input logic [ADC_W-1:0] hfStep,
  input logic             divBusy
);
  localparam int EW = ADC_W + 3;
  localparam logic [ADC_W-1:0] THR = ADC_W'(THRESH);
  localparam logic [EW-1:0]    DIV = EW'(BANDS);

  logic [ADC_W-1:0] lfJump, hfJump;
  logic [EW-1:0]    stepTimes;

  assign lfJump    = (lfEvNew > lfEvOld) ? (lfEvNew - lfEvOld) : (lfEvOld - lfEvNew);
  assign hfJump    = (hfEvNew > hfEvOld) ? (hfEvNew - hfEvOld) : (hfEvOld - hfEvNew);
  assign stepTimes = EW'(hfStep) * DIV;

  AST_STOP_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_STOPPED) |=> (ledOut == 4'b0000));                       // R8
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_STOPPED) |=> (!lfEvent && !hfEvent));                    // R8
  AST_DETECT_NO_AC: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_DETECT) |=> (!ledOut[3] && !ledOut[1]));                 // R2
  AST_LF_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    lfEvent |-> (lfJump > THR));                                           // R3
  AST_HF_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    hfEvent |-> (hfJump > THR));                                           // R3
  AST_HF_LIMITED: assert property (@(posedge clk) disable iff (!rstN)
    hfEvent |-> ($past(limit) != LIMIT_NO_HF));                            // R10
  AST_LF_LIMITED: assert property (@(posedge clk) disable iff (!rstN)
    lfEvent |-> ($past(limit) != LIMIT_NO_LF));                            // R10
  AST_MAX_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    hfEvent |-> (hfMax >= hfEvNew));                                       // R5
  AST_STEP_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    !divBusy |-> ((stepTimes <= EW'(hfMax)) && (EW'(hfMax) < stepTimes + DIV))); // R5

endmodule

bind fieldMeter fmCheck #(.ADC_W(ADC_W), .THRESH(THRESH)) chk (
  .clk(clk), .rstN(rstN), .mode(modeW), .limit(limit), .ledOut(ledOut),
  .lfEvent(lfEvent), .lfEvOld(lfEvOld), .lfEvNew(lfEvNew),
  .hfEvent(hfEvent), .hfEvOld(hfEvOld), .hfEvNew(hfEvNew),
  .hfMax(hfMaxW), .hfStep(hfStepW), .divBusy(divBusyW)
);

// File: tb/fieldMeter_test.sv
module fieldMeter_test;
  localparam int AW   = 10;
  localparam int TH   = 10;
  localparam int CW   = 8;
  localparam int HOLD = 30;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, buttonPress, lfValid, hfValid;
  logic [1:0]    limit;
  logic [AW-1:0] lfSample, hfSample;
  logic [3:0]    ledOut;
  logic          lfEvent, hfEvent;
  logic [AW-1:0] lfEvOld, lfEvNew, hfEvOld, hfEvNew;
  logic [CW-1:0] lfEvCount, hfEvCount;

  fieldMeter #(.ADC_W(AW), .THRESH(TH), .CNT_W(CW), .HOLDOFF_CYCLES(HOLD)) uut (
    .clk(clk), .rstN(rstN), .limit(limit), .buttonPress(buttonPress),
    .lfValid(lfValid), .lfSample(lfSample), .hfValid(hfValid), .hfSample(hfSample),
    .ledOut(ledOut),
    .lfEvent(lfEvent), .lfEvOld(lfEvOld), .lfEvNew(lfEvNew), .lfEvCount(lfEvCount),
    .hfEvent(hfEvent), .hfEvOld(hfEvOld), .hfEvNew(hfEvNew), .hfEvCount(hfEvCount)
  );

  int checks = 0;
  int errors = 0;

  // requirement model: index 0 low-frequency, 1 high-frequency
  int mBase [2];
  int mLvl  [2];
  int mCnt  [2];
  bit mHave [2];
  int mMax;
  int mMode;   // 0 detect, 1 strength, 2 stopped
  int mLimit;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(input int a);
    return (a < 0) ? -a : a;
  endfunction

  function automatic int pattern(input int b);
    case (b)
      6: return 15;
      5: return 13;
      4: return 5;
      3: return 1;
      2: return 4;
      1: return 8;
      default: return 2;
    endcase
  endfunction

  function automatic int expLeds();
    bit lfP, hfP;
    int step, band;
    lfP = mHave[0] && (mLimit != 2) && (iabs(mLvl[0] - mBase[0]) > TH);
    hfP = mHave[1] && (mLimit != 1) && (iabs(mLvl[1] - mBase[1]) > TH);
    if (mMode == 0) return (hfP ? 4 : 0) + (lfP ? 1 : 0);
    if (mMode == 1) begin
      if (!hfP || mLvl[1] == 0) return 0;
      step = mMax / 7;
      band = 0;
      for (int k = 1; k <= 6; k++) if (mLvl[1] > k * step) band++;
      return pattern(band);
    end
    return 0;
  endfunction

  task automatic resetDut(input int lim);
    rstN = 1'b0; buttonPress = 1'b0; lfValid = 1'b0; hfValid = 1'b0;
    lfSample = '0; hfSample = '0; limit = 2'(lim);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < 2; c++) begin
      mBase[c] = 0; mLvl[c] = 0; mCnt[c] = 0; mHave[c] = 1'b0;
    end
    mMax = 0; mMode = 0; mLimit = lim;
  endtask

  task automatic sendSample(input int ch, input int v, input string req);
    int expEv, eOld, eNew, eCnt;
    bit en;
    @(negedge clk);
    if (ch == 0) begin lfSample = AW'(v); lfValid = 1'b1; end
    else         begin hfSample = AW'(v); hfValid = 1'b1; end
    @(negedge clk);
    lfValid = 1'b0; hfValid = 1'b0;
    expEv = 0; eOld = 0; eNew = 0; eCnt = 0;
    en = (ch == 0) ? (mLimit != 2) : (mLimit != 1);
    if (mMode != 2 && en) begin
      if (!mHave[ch]) begin
        mHave[ch] = 1'b1; mBase[ch] = v; mLvl[ch] = v; mCnt[ch] = 0;
        if (ch == 1) mMax = v;
      end else if (iabs(v - mLvl[ch]) > TH) begin
        expEv = 1; eOld = mLvl[ch]; eNew = v;
        eCnt = (mCnt[ch] + 1 > CMAX) ? CMAX : mCnt[ch] + 1;
        mLvl[ch] = v; mCnt[ch] = 0;
        if (ch == 1 && v > mMax) mMax = v;
      end else begin
        mCnt[ch] = (mCnt[ch] + 1 > CMAX) ? CMAX : mCnt[ch] + 1;
      end
    end
    if (ch == 0) begin
      check(req, "lf event strobe", int'(lfEvent), expEv);
      if (expEv == 1) begin
        check(req, "lf old level", int'(lfEvOld), eOld);
        check(req, "lf new level", int'(lfEvNew), eNew);
        check("R4", "lf event count", int'(lfEvCount), eCnt);
      end
    end else begin
      check(req, "hf event strobe", int'(hfEvent), expEv);
      if (expEv == 1) begin
        check(req, "hf old level", int'(hfEvOld), eOld);
        check(req, "hf new level", int'(hfEvNew), eNew);
        check("R4", "hf event count", int'(hfEvCount), eCnt);
      end
    end
  endtask

  task automatic ledCheck(input string req);
    repeat (22) @(negedge clk);
    check(req, "leds", int'(ledOut), expLeds());
  endtask

  task automatic press(input bit accepted);
    @(negedge clk);
    buttonPress = 1'b1;
    @(negedge clk);
    buttonPress = 1'b0;
    if (accepted && mMode != 2) mMode = mMode + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    resetDut(0);
    @(negedge clk);
    check("R1", "reset leds", int'(ledOut), 0);
    check("R1", "reset lf strobe", int'(lfEvent), 0);
    check("R1", "reset hf strobe", int'(hfEvent), 0);

    // references, then small and large changes (R1, R2, R3, R4)
    sendSample(0, 500, "R1");
    sendSample(1, 100, "R1");
    ledCheck("R2");
    sendSample(0, 505, "R3");
    sendSample(0, 520, "R3");
    ledCheck("R2");
    sendSample(1, 800, "R3");
    sendSample(1, 795, "R3");
    ledCheck("R2");

    // count saturation on small wobble, then a real change (R4)
    for (int i = 0; i < 300; i++) sendSample(0, 520 + (i % 2) * 5, "R4");
    sendSample(0, 300, "R4");
    ledCheck("R2");

    // strength mode, then a press inside the hold-off window (R8, R9)
    press(1'b1);
    ledCheck("R8");
    press(1'b0);
    ledCheck("R9");
    repeat (HOLD + 10) @(negedge clk);

    // band sweep upward across the range, the maximum grows past 800 (R5, R6, R7)
    for (int v = 0; v <= 1023; v += 11) begin
      sendSample(1, v, (v > mMax) ? "R5" : "R6");
      ledCheck((mLvl[1] == 0) ? "R7" : "R6");
    end
    // downward sweep with steps below the threshold (R3, R6)
    for (int v = 1023; v >= 0; v -= 7) begin
      sendSample(1, v, "R3");
      ledCheck("R6");
    end
    sendSample(1, 500, "R6");
    sendSample(0, 900, "R7");
    ledCheck("R7");
    sendSample(1, 105, "R7");
    ledCheck("R7");
    sendSample(1, 0, "R7");
    ledCheck("R7");
    sendSample(1, 1000, "R6");
    ledCheck("R6");

    // stop, then ignored readings and presses (R8)
    press(1'b1);
    ledCheck("R8");
    sendSample(0, 10, "R8");
    sendSample(1, 10, "R8");
    repeat (HOLD + 10) @(negedge clk);
    press(1'b0);
    ledCheck("R8");

    // high-frequency channel off (R10)
    resetDut(1);
    sendSample(1, 300, "R10");
    sendSample(1, 900, "R10");
    sendSample(0, 400, "R10");
    sendSample(0, 600, "R10");
    ledCheck("R10");

    // low-frequency channel off (R10)
    resetDut(2);
    sendSample(0, 400, "R10");
    sendSample(0, 900, "R10");
    sendSample(1, 200, "R10");
    sendSample(1, 700, "R10");
    ledCheck("R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule